// File: doc/BRIEF.md
# SDRAM Bank Precharge Timing Monitor

The monitor samples the command strobes of an SDRAM bus on every rising clock edge. It keeps a model of four banks: whether each is open, how long it must still wait before a precharge is allowed, and how long it must still wait before an activate is allowed. It never drives the bus. It raises a one-cycle pulse when a command breaks a precharge rule. The three rule classes are: a precharge that comes too soon after a read or write burst, an activate that comes too soon after the bank was closed, and a read or write sent to a closed bank. Each pulse comes with the index of the bank at fault.

Burst length, CAS latency, the write-data-to-precharge delay, the precharge time and the auto-precharge write-to-activate delay are elaboration parameters in clock cycles. Auto-precharge is covered for reads and for writes. That includes a write with auto-precharge whose burst is cut short by a later column command. In that case the activate window of the written bank is counted from its last real data cycle. The monitor is meant to sit beside a memory controller in simulation, or in silicon as a protocol watchdog.

Top module: `sdram_pre_mon`

## Requirements
- R1: Commands are decoded from (cs_n, ras_n, cas_n, we_n) at the rising edge: 0011 activate, 0101 read, 0100 write, 0010 precharge. Every other code with cs_n low is treated as no-operation. After reset, bank_open is 0 and all pulses and indices are 0.
- R2: An activate to bank ba sets bank_open[ba] in the cycle after the command. An activate to a bank that is already open leaves it open.
- R3: A precharge with a10 low closes only bank ba. A precharge with a10 high closes every bank and ignores ba. A precharge of a bank that is already closed changes nothing.
- R4: A precharge to an open bank fewer than BL cycles after a read to it pulses viol_pre. At BL cycles or more, no pulse.
- R5: A precharge to an open bank fewer than BL-1+TDPL cycles after a write (without auto-precharge) to it pulses viol_pre. Where a read and a write both apply, the later deadline wins.
- R6: An activate fewer than TRP cycles after a precharge closed that bank pulses viol_act.
- R7: A read or write to a closed bank pulses viol_acc with viol_acc_bank = ba. It changes no timer of that bank.
- R8: A write with a10 high to an open bank closes it. An activate fewer than BL-1+TDAL cycles after that write pulses viol_act.
- R9: If any read or write arrives d cycles after a write with auto-precharge, with 1 <= d < BL, the write bank's activate limit becomes d-1+TDAL cycles after the write.
- R10: A read with a10 high to an open bank closes it. An activate fewer than BL+TRP cycles after that read pulses viol_act.
- R11: With cs_n high, bank state and pending limits do not change, apart from time passing. No pulse results.
- R12: An all-bank precharge is checked against every open bank. viol_pre_bank names the lowest-numbered bank at fault.
- R13: Every violation pulse appears in the cycle after the offending command and lasts one cycle per offending command. Each index output reads 0 while its pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples commands |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| a10 | input | 1 | All-bank flag on precharge, auto-precharge flag on read/write |
| ba | input | 2 | Bank address |
| bank_open | output | 4 | One bit per bank, set while the bank is open |
| viol_pre | output | 1 | Early precharge pulse |
| viol_pre_bank | output | 2 | Bank of the early precharge |
| viol_act | output | 1 | Early activate pulse |
| viol_act_bank | output | 2 | Bank of the early activate |
| viol_acc | output | 1 | Closed-bank access pulse |
| viol_acc_bank | output | 2 | Bank of the closed-bank access |

## Verification
A wrong open flag is visible on bank_open one cycle after the command that caused it. A later read or write to that bank then raises or hides viol_acc. A wrong countdown cannot be seen until the next precharge or activate to that bank. At that point viol_pre or viol_act flips at the cycle edge where the limit falls, so stimulus has to probe distances just below and just at each limit. A wrong auto-precharge burst length shows only when a column command lands inside the burst and is followed by an activate near the shortened limit.

// File: rtl/sdram_mon_pkg.sv
// Package: shared command type and helpers for the precharge monitor.
// Assumes the command strobes are active low and sampled at the rising edge.
package sdram_mon_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    // Map strobe levels to a command; unknown codes become no-operation.
    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        cmd_e c;
        c = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
// Module: sdram_cmd_decode
// Turns the four command strobes into one command code. Purely
// combinational; assumes the strobes are stable around the clock edge.
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Decode the strobes into the command code.
    always_comb begin
        cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);
    end

endmodule

// File: rtl/sdram_bank_track.sv
// Module: sdram_bank_track
// State of one bank: open flag, precharge countdown and activate countdown.
// A countdown loaded with N-1 at a command reaches zero exactly N cycles
// later; a command is legal when the matching countdown reads zero.
// Assumes BL >= 1, TDPL >= 1, TRP >= 1 and TDAL >= 2.
module sdram_bank_track
    import sdram_mon_pkg::*;
#(
    parameter int BL   = 4,
    parameter int CL   = 3,
    parameter int TDPL = 2,
    parameter int TRP  = 3,
    parameter int TDAL = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    input  logic sel,
    input  logic a10,
    input  logic ap_intr,
    output logic open_o,
    output logic pre_viol,
    output logic act_viol
);

    // Read: last data at CL+BL-1, precharge allowed CL-1 before that.
    localparam int RD_PRE   = (CL + BL - 1) - (CL - 1);
    localparam int WR_PRE   = BL - 1 + TDPL;
    localparam int WRAP_ACT = BL - 1 + TDAL;
    localparam int RDAP_ACT = BL + TRP;
    localparam int PRE_MAX  = max2(RD_PRE, WR_PRE);
    localparam int ACT_MAX  = max2(max2(TRP, WRAP_ACT), max2(RDAP_ACT, TDAL));
    localparam int PW       = $clog2(PRE_MAX + 1);
    localparam int AW       = $clog2(ACT_MAX + 1);

    logic          is_open;
    logic [PW-1:0] pre_cnt;
    logic [AW-1:0] act_cnt;
    logic [PW-1:0] pre_dec;
    logic [PW-1:0] pre_new;
    logic [AW-1:0] act_dec;
    logic          act_here;
    logic          col_here;
    logic          pre_hit;

    // Per-bank view of the bus command.
    always_comb begin
        act_here = (cmd == CMD_ACT) && sel;
        col_here = ((cmd == CMD_RD) || (cmd == CMD_WR)) && sel && is_open;
        pre_hit  = (cmd == CMD_PRE) && (a10 || sel) && is_open;
        pre_dec  = (pre_cnt == '0) ? '0 : pre_cnt - 1'b1;
        act_dec  = (act_cnt == '0) ? '0 : act_cnt - 1'b1;
        pre_new  = pre_dec;
        if (col_here && (cmd == CMD_RD) && (PW'(RD_PRE - 1) > pre_dec))
            pre_new = PW'(RD_PRE - 1);
        if (col_here && (cmd == CMD_WR) && !a10 && (PW'(WR_PRE - 1) > pre_dec))
            pre_new = PW'(WR_PRE - 1);
    end

    // Open flag: activate opens, precharge or auto-precharge closes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            is_open <= 1'b0;
        else if (act_here)
            is_open <= 1'b1;
        else if (pre_hit || (col_here && a10))
            is_open <= 1'b0;
    end

    // Precharge countdown: longest pending burst limit wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_new;
    end

    // Activate countdown: loaded when the bank closes or its burst is cut.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_cnt <= '0;
        else if (col_here && a10 && (cmd == CMD_RD))
            act_cnt <= AW'(RDAP_ACT - 1);
        else if (col_here && a10 && (cmd == CMD_WR))
            act_cnt <= AW'(WRAP_ACT - 1);
        else if (ap_intr)
            act_cnt <= AW'(TDAL - 2);
        else if (pre_hit)
            act_cnt <= AW'(TRP - 1);
        else
            act_cnt <= act_dec;
    end

    // Rule checks for this bank.
    always_comb begin
        open_o   = is_open;
        pre_viol = pre_hit && (pre_cnt != '0);
        act_viol = act_here && (act_cnt != '0);
    end

    p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act_here |=> open_o);

    p_pre_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_hit |=> !open_o);

    p_trp_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_hit && (TRP > 1) && !ap_intr) |=> (act_cnt != '0));

    p_rd_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_here && (cmd == CMD_RD) && (RD_PRE > 1)) |=> (pre_cnt != '0));

endmodule

// File: rtl/sdram_ap_tracker.sv
// Module: sdram_ap_tracker
// Follows the data burst of the latest write with auto-precharge. A read
// or write landing inside that burst cuts it short and tells the written
// bank to restart its activate limit from the cut. Assumes BL >= 1.
module sdram_ap_tracker
    import sdram_mon_pkg::*;
#(
    parameter int BL   = 4,
    parameter int BA_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cmd_e                 cmd,
    input  logic                 a10,
    input  logic [BA_W-1:0]      ba,
    input  logic [(1<<BA_W)-1:0] open_vec,
    output logic [(1<<BA_W)-1:0] intr_vec
);

    localparam int NB = 1 << BA_W;
    localparam int LW = $clog2(BL + 1);

    logic [LW-1:0]   left;
    logic [BA_W-1:0] wr_bank;
    logic            col;
    logic            start;

    // Burst cut detection and new burst start.
    always_comb begin
        col      = (cmd == CMD_RD) || (cmd == CMD_WR);
        start    = (cmd == CMD_WR) && a10 && open_vec[ba];
        intr_vec = '0;
        if (col && (left != '0))
            intr_vec[wr_bank] = 1'b1;
    end

    // Remaining burst cycles of the tracked auto-precharge write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left    <= '0;
            wr_bank <= '0;
        end else if (start) begin
            left    <= LW'(BL - 1);
            wr_bank <= ba;
        end else if (col) begin
            left    <= '0;
        end else if (left != '0) begin
            left    <= left - 1'b1;
        end
    end

    p_start_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (left == LW'(BL - 1)) && (wr_bank == $past(ba)));

    p_cut_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (col && !start) |=> (left == '0));

    p_one_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(intr_vec));

    initial begin
        assert (NB >= 2) else $error("bank count too small");
    end

endmodule

// File: rtl/sdram_pre_mon.sv
// Module: sdram_pre_mon (top)
// Precharge timing monitor for a four-bank SDRAM command bus. Decodes the
// strobes, keeps one tracker per bank plus the auto-precharge burst
// tracker, and registers three violation pulses with bank indices.
// Assumes all timing parameters are in clock cycles and TDAL >= 2.
module sdram_pre_mon
    import sdram_mon_pkg::*;
#(
    parameter int BL   = 4,
    parameter int CL   = 3,
    parameter int TDPL = 2,
    parameter int TRP  = 3,
    parameter int TDAL = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       a10,
    input  logic [1:0] ba,
    output logic [3:0] bank_open,
    output logic       viol_pre,
    output logic [1:0] viol_pre_bank,
    output logic       viol_act,
    output logic [1:0] viol_act_bank,
    output logic       viol_acc,
    output logic [1:0] viol_acc_bank
);

    localparam int BA_W = 2;
    localparam int NB   = 1 << BA_W;

    cmd_e            cmd;
    logic [NB-1:0]   open_vec;
    logic [NB-1:0]   pre_v;
    logic [NB-1:0]   act_v;
    logic [NB-1:0]   intr_vec;
    logic [BA_W-1:0] pre_idx;
    logic            acc_now;

    sdram_cmd_decode u_dec (
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .cmd  (cmd)
    );

    sdram_ap_tracker #(.BL(BL), .BA_W(BA_W)) u_ap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .a10     (a10),
        .ba      (ba),
        .open_vec(open_vec),
        .intr_vec(intr_vec)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        sdram_bank_track #(
            .BL(BL), .CL(CL), .TDPL(TDPL), .TRP(TRP), .TDAL(TDAL)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd     (cmd),
            .sel     (ba == BA_W'(b)),
            .a10     (a10),
            .ap_intr (intr_vec[b]),
            .open_o  (open_vec[b]),
            .pre_viol(pre_v[b]),
            .act_viol(act_v[b])
        );
    end

    // Lowest offending bank of a precharge, closed-bank access detect.
    always_comb begin
        pre_idx = '0;
        for (int b = NB - 1; b >= 0; b--)
            if (pre_v[b]) pre_idx = BA_W'(b);
        acc_now = ((cmd == CMD_RD) || (cmd == CMD_WR)) && !open_vec[ba];
        bank_open = open_vec;
    end

    // Registered violation pulses and their bank indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_pre      <= 1'b0;
            viol_pre_bank <= '0;
            viol_act      <= 1'b0;
            viol_act_bank <= '0;
            viol_acc      <= 1'b0;
            viol_acc_bank <= '0;
        end else begin
            viol_pre      <= |pre_v;
            viol_pre_bank <= (|pre_v) ? pre_idx : '0;
            viol_act      <= |act_v;
            viol_act_bank <= (|act_v) ? ba : '0;
            viol_acc      <= acc_now;
            viol_acc_bank <= acc_now ? ba : '0;
        end
    end

    p_closed_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && ras_n && !cas_n && !bank_open[ba]) |=>
            (viol_acc && (viol_acc_bank == $past(ba))));

    p_cs_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(bank_open) && !viol_pre && !viol_act && !viol_acc));

    p_idx_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!viol_pre |-> (viol_pre_bank == '0)) and
        (!viol_act |-> (viol_act_bank == '0)));

    p_all_pre_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && cas_n && !we_n && a10) |=> (bank_open == '0));

endmodule

// File: tb/sim_sdram_pre_mon.sv
// Bench: random and directed command streams, checked against a timing
// model held in absolute cycle numbers.
module sim_sdram_pre_mon;

    localparam int BL = 4, CL = 3, TDPL = 2, TRP = 3, TDAL = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [3:0] bank_open;
    logic viol_pre, viol_act, viol_acc;
    logic [1:0] viol_pre_bank, viol_act_bank, viol_acc_bank;

    int checks = 0, errors = 0;
    bit done = 0;

    // model state
    bit  m_open [4];
    int  m_pre_rdy [4];
    int  m_act_rdy [4];
    int  m_ap_t0 = -100;
    int  m_ap_bank = 0;
    int  now = 0;
    bit  e_pre, e_act, e_acc;
    int  e_pre_b, e_act_b, e_acc_b;
    string tag = "R1";

    always #4 clk = ~clk;

    sdram_pre_mon #(.BL(BL), .CL(CL), .TDPL(TDPL), .TRP(TRP), .TDAL(TDAL)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .a10(a10), .ba(ba), .bank_open(bank_open),
        .viol_pre(viol_pre), .viol_pre_bank(viol_pre_bank),
        .viol_act(viol_act), .viol_act_bank(viol_act_bank),
        .viol_acc(viol_acc), .viol_acc_bank(viol_acc_bank)
    );

    function automatic int exp_open_vec();
        int v = 0;
        for (int b = 0; b < 4; b++) if (m_open[b]) v |= (1 << b);
        return v;
    endfunction

    task automatic check(input string t);
        checks++;
        if (bank_open !== 4'(exp_open_vec())) begin
            errors++;
            $display("FAIL %s bank_open act=%b exp=%b", t, bank_open, 4'(exp_open_vec()));
        end
        checks++;
        if ({viol_pre, viol_pre_bank, viol_act, viol_act_bank, viol_acc, viol_acc_bank} !==
            {e_pre, 2'(e_pre_b), e_act, 2'(e_act_b), e_acc, 2'(e_acc_b)}) begin
            errors++;
            $display("FAIL %s pulses act=%b%0d %b%0d %b%0d exp=%b%0d %b%0d %b%0d", t,
                     viol_pre, viol_pre_bank, viol_act, viol_act_bank, viol_acc, viol_acc_bank,
                     e_pre, e_pre_b, e_act, e_act_b, e_acc, e_acc_b);
        end
    endtask

    // Apply one command after a negedge and update the model (R1 codes).
    task automatic issue(input logic c, input logic r, input logic ca,
                         input logic w, input logic a, input logic [1:0] b,
                         input string t);
        int bi = int'(b);
        bit is_act, is_rd, is_wr, is_pre;
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; a10 = a; ba = b;
        is_act = !c && ({r, ca, w} == 3'b011);
        is_rd  = !c && ({r, ca, w} == 3'b101);
        is_wr  = !c && ({r, ca, w} == 3'b100);
        is_pre = !c && ({r, ca, w} == 3'b010);
        e_pre = 0; e_act = 0; e_acc = 0; e_pre_b = 0; e_act_b = 0; e_acc_b = 0;
        if (is_pre) begin
            for (int k = 3; k >= 0; k--)
                if ((a || k == bi) && m_open[k] && now < m_pre_rdy[k]) begin
                    e_pre = 1; e_pre_b = k;
                end
            for (int k = 0; k < 4; k++)
                if ((a || k == bi) && m_open[k]) begin
                    m_open[k] = 0; m_act_rdy[k] = now + TRP;
                end
        end
        if (is_act) begin
            if (now < m_act_rdy[bi]) begin e_act = 1; e_act_b = bi; end
            m_open[bi] = 1;
        end
        if (is_rd || is_wr) begin
            if (now - m_ap_t0 < BL && now - m_ap_t0 >= 1)
                m_act_rdy[m_ap_bank] = now - 1 + TDAL;
            m_ap_t0 = -100;
            if (!m_open[bi]) begin
                e_acc = 1; e_acc_b = bi;
            end else if (is_rd) begin
                if (now + BL > m_pre_rdy[bi]) m_pre_rdy[bi] = now + BL;
                if (a) begin m_open[bi] = 0; m_act_rdy[bi] = now + BL + TRP; end
            end else if (a) begin
                m_open[bi] = 0; m_act_rdy[bi] = now + BL - 1 + TDAL;
                m_ap_t0 = now; m_ap_bank = bi;
            end else begin
                if (now + BL - 1 + TDPL > m_pre_rdy[bi]) m_pre_rdy[bi] = now + BL - 1 + TDPL;
            end
        end
        tag = t;
        @(negedge clk);
        now++;
        check(tag);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) issue(1, 1, 1, 1, 0, 0, "R11");
    endtask
    task automatic act(input int b, input string t);  issue(0, 0, 1, 1, 0, 2'(b), t); endtask
    task automatic rd(input int b, input bit a, input string t);  issue(0, 1, 0, 1, a, 2'(b), t); endtask
    task automatic wr(input int b, input bit a, input string t);  issue(0, 1, 0, 0, a, 2'(b), t); endtask
    task automatic pre(input int b, input bit a, input string t); issue(0, 0, 1, 0, a, 2'(b), t); endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_pre_rdy[b] = 0; m_act_rdy[b] = 0; end
        e_pre = 0; e_act = 0; e_acc = 0; e_pre_b = 0; e_act_b = 0; e_acc_b = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset");
        // R2 open, R7 closed access
        rd(1, 0, "R7 read closed");
        act(0, "R2 activate");
        act(0, "R2 reactivate open");
        // R4 read then early and on-time precharge
        rd(0, 0, "R4 read");
        nop(BL - 2);
        pre(0, 0, "R4 early precharge");
        nop(TRP - 2);
        act(0, "R6 early activate");
        nop(TRP);
        rd(0, 0, "R4 read");
        nop(BL - 1);
        pre(0, 0, "R4 on-time precharge");
        nop(TRP - 1);
        act(0, "R6 on-time activate");
        // R5 write then precharge limits
        wr(0, 0, "R5 write");
        nop(BL - 2 + TDPL - 1);
        pre(0, 0, "R5 early precharge");
        nop(TRP); act(0, "R2");
        wr(0, 0, "R5 write");
        nop(BL - 2 + TDPL);
        pre(0, 0, "R5 on-time precharge");
        // R3 single vs all-bank, R12 lowest index
        nop(TRP); act(0, "R2"); act(2, "R2"); act(3, "R2");
        pre(2, 0, "R3 single bank");
        act(2, "R6 early after single");
        rd(3, 0, "R12 read b3"); wr(2, 0, "R12 write b2");
        pre(1, 1, "R12 all-bank early");
        nop(8);
        // R8 auto-precharge write uninterrupted
        act(1, "R2");
        wr(1, 1, "R8 write auto-precharge");
        nop(BL - 1 + TDAL - 2);
        act(1, "R8 early activate");
        pre(1, 0, "R3"); nop(TRP + 1);
        act(1, "R2");
        wr(1, 1, "R8 write auto-precharge");
        nop(BL - 1 + TDAL - 1);
        act(1, "R8 on-time activate");
        // R9 interrupted write: read at d=2, limit 1+TDAL
        act(2, "R2"); nop(TRP);
        wr(1, 1, "R9 write auto-precharge");
        nop(1);
        rd(2, 0, "R9 cutting read");
        nop(TDAL - 3);
        act(1, "R9 early activate");
        pre(1, 0, "R3"); nop(TRP + 1); act(1, "R2");
        wr(1, 1, "R9 write auto-precharge");
        nop(1);
        rd(2, 0, "R9 cutting read");
        nop(TDAL - 2);
        act(1, "R9 on-time activate");
        // R10 read with auto-precharge
        rd(1, 1, "R10 read auto-precharge");
        nop(BL + TRP - 2);
        act(1, "R10 early activate");
        nop(10);
        // R11 chip-select high with command-like strobes
        issue(1, 0, 1, 0, 1, 2'd0, "R11 cs high precharge code");
        issue(1, 1, 0, 1, 0, 2'd3, "R11 cs high read code");
        // random stream
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            int sel = $urandom_range(0, 9);
            logic [1:0] bb = 2'($urandom_range(0, 3));
            bit aa = ($urandom_range(0, 3) == 0);
            case (sel)
                0, 1: nop(1);
                2, 3: act(bb, "R6 random activate");
                4:    rd(bb, aa, "R10 random read");
                5:    rd(bb, 0, "R4 random read");
                6:    wr(bb, aa, "R9 random write");
                7:    pre(bb, aa, "R12 random precharge");
                8:    pre(bb, 0, "R5 random precharge");
                default: issue(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                               aa, bb, "R13 random strobes");
            endcase
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule